// File: doc/BRIEF.md
# Two-Wire Register Access Master

This block is a hardware master for a two-wire serial management link that shares the clock and data pins of an MDIO bus but frames its traffic differently. The host asks for one 16-bit register read or write. The block then drives the whole exchange bit by bit. An exchange is a start pattern, a command byte, a 16-bit address sent low byte first, and a 16-bit data word. The slave acknowledges every byte the master writes, and the master closes the two read data bytes with acknowledge bits of its own. A stop pattern ends the exchange and releases both lines.

The host port is a single request/response pair. Start is a one-cycle pulse taken only while the block is idle. Busy covers the whole exchange, and a one-cycle done pulse carries the error flag and the read data. The read and write command codes and the pacing delay are configuration inputs. Every pin change is followed by `cfg_delay` clock cycles of wait, and a delay of zero counts as one. The controller walks the states IDLE, START, SEND, ACK, RECV, MACK, STOP and FIN:
- IDLE to START on a request.
- START to SEND after the start pattern.
- SEND to ACK after each byte. For a no-ack write, SEND goes to STOP after the last byte instead.
- ACK to ACK on a retry.
- ACK to SEND for the next byte.
- ACK to RECV after the high address byte of a read.
- ACK to STOP when the write is complete or the retries are exhausted.
- RECV to MACK.
- MACK to RECV after the low data byte, and MACK to STOP after the high data byte.
- STOP to FIN, and FIN back to IDLE.

Top module: `sermgmt_master`

## Requirements
- R1: Out of reset and whenever busy is low, both output enables are low, and busy and done are low.
- R2: An exchange opens with both enables raised, clock low and data high. One full clock pulse follows. On the second clock high, data falls while the clock stays high. The clock then falls and data returns high. The two rising clock edges of this pattern see data at 1, and no other falling data edge with the clock high occurs in the exchange.
- R3: Written bits go out most significant bit first. Data changes only while the clock is low. The only data changes made while the clock is high are the start fall and the stop rise.
- R4: A read sends the read command byte, the low address byte and the high address byte. It then clocks in the low data byte, sends a master acknowledge of 0, clocks in the high data byte and sends a master acknowledge of 1. Read data bits 7:0 come from the first received byte and bits 15:8 from the second, and both bytes are sampled while the clock is high.
- R5: A write sends the write command byte, the low address byte, the high address byte, the low data byte and the high data byte, in that order.
- R6: After each byte the master writes, it releases the data line and clocks in one acknowledge bit, where 0 means accepted. If the bit is 1, it clocks in another acknowledge bit. Up to 5 retries are allowed, so six acknowledge clocks in total.
- R7: If the sixth acknowledge bit is still 1, the remaining bytes are skipped, the stop pattern is still sent, and the error flag is 1 with done.
- R8: With the no-ack option, a write does not clock an acknowledge after its high data byte. The option has no effect on reads.
- R9: The stop pattern drives data low as the clock rises, then raises data while the clock is high. The clock then goes low, high, low and high, and both enables drop. Its three rising clock edges see data 0, 1 and 1.
- R10: Consecutive pin changes are separated by exactly `cfg_delay` cycles or a whole multiple of it, with 0 treated as 1.
- R11: A start pulse while idle raises busy on the next cycle. A start pulse while busy is ignored. Done lasts one cycle per exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request pulse |
| req_read | input | 1 | 1 for read, 0 for write |
| req_noack | input | 1 | Skip the acknowledge after the final write byte |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| cfg_rd_cmd | input | 8 | Command code sent for reads |
| cfg_wr_cmd | input | 8 | Command code sent for writes |
| cfg_delay | input | DELAY_W | Cycles of wait after each pin change |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with done |
| rsp_err | output | 1 | Acknowledge timeout, valid with done |
| mgmt_clk_o | output | 1 | Management clock level |
| mgmt_clk_oe | output | 1 | Management clock drive enable |
| mgmt_dat_o | output | 1 | Management data level |
| mgmt_dat_oe | output | 1 | Management data drive enable |
| mgmt_dat_i | input | 1 | Management data input |

## Verification
The pacing assertion relies on `cfg_delay` staying constant during an exchange. The bench changes it only between exchanges, while busy is low. The assertions also rely on `mgmt_dat_i` mattering only while the data enable is low. The bench loops the driven level back whenever the master drives, and otherwise feeds the next bit from a prepared response stream, advanced on each falling management clock with the line released. Request fields are latched when a request is accepted, so the bench may change them freely while busy, and one test does so with a second start pulse.

// File: rtl/sermgmt_pkg.sv
package sermgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_ACK,
        ST_RECV,
        ST_MACK,
        ST_STOP,
        ST_FIN
    } sm_state_e;

    localparam int unsigned LAST_BYTE = 4;

    // Byte order on the wire: command, address low, address high, data low, data high
    function automatic logic [7:0] pick_byte(
        input logic [2:0]  idx,
        input logic        is_rd,
        input logic [7:0]  rd_cmd,
        input logic [7:0]  wr_cmd,
        input logic [15:0] addr,
        input logic [15:0] wdat
    );
        logic [7:0] b;
        case (idx)
            3'd0:    b = is_rd ? rd_cmd : wr_cmd;
            3'd1:    b = addr[7:0];
            3'd2:    b = addr[15:8];
            3'd3:    b = wdat[7:0];
            3'd4:    b = wdat[15:8];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sermgmt_pacer.sv
module sermgmt_pacer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [DELAY_W-1:0] dly,
    output logic               go
);
    logic [DELAY_W-1:0] cnt;
    logic [DELAY_W-1:0] eff;

    assign eff = (dly == '0) ? DELAY_W'(1) : dly;
    assign go  = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (go)      cnt <= eff - DELAY_W'(1);
        else              cnt <= cnt - DELAY_W'(1);
    end

    // R10
    go_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && eff != DELAY_W'(1)) |=> !go);

endmodule

// File: rtl/sermgmt_seq.sv
module sermgmt_seq
    import sermgmt_pkg::*;
#(
    parameter int ACK_RETRIES = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    output logic        run,
    input  logic        req_start,
    input  logic        req_read,
    input  logic        req_noack,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [7:0]  cfg_rd_cmd,
    input  logic [7:0]  cfg_wr_cmd,
    output logic        busy,
    output logic        done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        mgmt_clk_o,
    output logic        mgmt_clk_oe,
    output logic        mgmt_dat_o,
    output logic        mgmt_dat_oe,
    input  logic        mgmt_dat_i
);
    localparam int TW = $clog2(ACK_RETRIES + 1);
    localparam logic [TW-1:0] RMAX = TW'(ACK_RETRIES);

    sm_state_e   st, st_n;
    logic [2:0]  sub, sub_n;
    logic [2:0]  bitn, bidx;
    logic [TW-1:0] tries;
    logic [7:0]  txsh, rxsh;
    logic        ackv, hi_byte, err_q;
    logic        q_read, q_noack;
    logic [15:0] q_addr, q_wdata, rdata_q;
    logic [7:0]  q_rdc, q_wrc;
    logic        skip_ack;

    assign skip_ack  = !q_read && q_noack && (bidx == 3'(LAST_BYTE));
    assign run       = (st != ST_IDLE) && (st != ST_FIN);
    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_FIN);
    assign rsp_err   = done && err_q;
    assign rsp_rdata = rdata_q;

    always_comb begin
        st_n  = st;
        sub_n = sub;
        unique case (st)
            ST_IDLE: if (req_start) begin st_n = ST_START; sub_n = 3'd0; end
            ST_START: if (go) begin
                if (sub == 3'd6) begin st_n = ST_SEND; sub_n = 3'd0; end
                else sub_n = sub + 3'd1;
            end
            ST_SEND: if (go) begin
                if (sub != 3'd2) sub_n = sub + 3'd1;
                else begin
                    sub_n = 3'd0;
                    if (bitn == 3'd0) st_n = skip_ack ? ST_STOP : ST_ACK;
                end
            end
            ST_ACK: if (go) begin
                if (sub != 3'd3) sub_n = sub + 3'd1;
                else begin
                    sub_n = 3'd0;
                    if (ackv) begin
                        if (tries == RMAX) st_n = ST_STOP;
                    end else if (bidx == 3'(LAST_BYTE)) st_n = ST_STOP;
                    else if (q_read && bidx == 3'd2)    st_n = ST_RECV;
                    else                                st_n = ST_SEND;
                end
            end
            ST_RECV: if (go) begin
                if (sub == 3'd2)      sub_n = (bitn == 3'd0) ? 3'd3 : 3'd1;
                else if (sub == 3'd3) begin sub_n = 3'd0; st_n = ST_MACK; end
                else                  sub_n = sub + 3'd1;
            end
            ST_MACK: if (go) begin
                if (sub != 3'd2) sub_n = sub + 3'd1;
                else begin sub_n = 3'd0; st_n = hi_byte ? ST_STOP : ST_RECV; end
            end
            ST_STOP: if (go) begin
                if (sub == 3'd7) begin st_n = ST_FIN; sub_n = 3'd0; end
                else sub_n = sub + 3'd1;
            end
            ST_FIN: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            sub <= 3'd0;
        end else begin
            st  <= st_n;
            sub <= sub_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mgmt_clk_o <= 1'b0; mgmt_clk_oe <= 1'b0;
            mgmt_dat_o <= 1'b1; mgmt_dat_oe <= 1'b0;
            bitn <= 3'd7; bidx <= 3'd0; tries <= '0;
            txsh <= 8'h00; rxsh <= 8'h00; ackv <= 1'b0;
            hi_byte <= 1'b0; err_q <= 1'b0; rdata_q <= 16'h0000;
            q_read <= 1'b0; q_noack <= 1'b0; q_addr <= 16'h0000;
            q_wdata <= 16'h0000; q_rdc <= 8'h00; q_wrc <= 8'h00;
        end else if (st == ST_IDLE) begin
            if (req_start) begin
                q_read <= req_read; q_noack <= req_noack;
                q_addr <= req_addr; q_wdata <= req_wdata;
                q_rdc  <= cfg_rd_cmd; q_wrc <= cfg_wr_cmd;
                txsh   <= req_read ? cfg_rd_cmd : cfg_wr_cmd;
                bitn <= 3'd7; bidx <= 3'd0; tries <= '0;
                hi_byte <= 1'b0; err_q <= 1'b0;
            end
        end else if (go) begin
            unique case (st)
                ST_START: case (sub)
                    3'd0: begin
                        mgmt_clk_oe <= 1'b1; mgmt_dat_oe <= 1'b1;
                        mgmt_clk_o  <= 1'b0; mgmt_dat_o  <= 1'b1;
                    end
                    3'd1, 3'd3: mgmt_clk_o <= 1'b1;
                    3'd2, 3'd5: mgmt_clk_o <= 1'b0;
                    3'd4:       mgmt_dat_o <= 1'b0;
                    default:    mgmt_dat_o <= 1'b1;
                endcase
                ST_SEND: case (sub)
                    3'd0: mgmt_dat_o <= txsh[7];
                    3'd1: mgmt_clk_o <= 1'b1;
                    default: begin
                        mgmt_clk_o <= 1'b0;
                        txsh <= {txsh[6:0], 1'b0};
                        if (bitn != 3'd0) bitn <= bitn - 3'd1;
                    end
                endcase
                ST_ACK: case (sub)
                    3'd0: mgmt_dat_oe <= 1'b0;
                    3'd1: mgmt_clk_o  <= 1'b1;
                    3'd2: begin mgmt_clk_o <= 1'b0; ackv <= mgmt_dat_i; end
                    default: begin
                        mgmt_dat_oe <= 1'b1; mgmt_dat_o <= 1'b0;
                        if (ackv) begin
                            if (tries == RMAX) err_q <= 1'b1;
                            else               tries <= tries + TW'(1);
                        end else begin
                            tries <= '0;
                            bidx  <= bidx + 3'd1;
                            bitn  <= 3'd7;
                            txsh  <= pick_byte(bidx + 3'd1, q_read, q_rdc, q_wrc,
                                               q_addr, q_wdata);
                        end
                    end
                endcase
                ST_RECV: case (sub)
                    3'd0: begin mgmt_dat_oe <= 1'b0; bitn <= 3'd7; end
                    3'd1: mgmt_clk_o <= 1'b1;
                    3'd2: begin
                        mgmt_clk_o <= 1'b0;
                        rxsh <= {rxsh[6:0], mgmt_dat_i};
                        if (bitn != 3'd0) bitn <= bitn - 3'd1;
                    end
                    default: begin
                        mgmt_dat_oe <= 1'b1; mgmt_dat_o <= 1'b0;
                        if (hi_byte) rdata_q[15:8] <= rxsh;
                        else         rdata_q[7:0]  <= rxsh;
                    end
                endcase
                ST_MACK: case (sub)
                    3'd0: mgmt_dat_o <= hi_byte;
                    3'd1: mgmt_clk_o <= 1'b1;
                    default: begin mgmt_clk_o <= 1'b0; hi_byte <= 1'b1; end
                endcase
                ST_STOP: case (sub)
                    3'd0: begin mgmt_dat_o <= 1'b0; mgmt_clk_o <= 1'b1; end
                    3'd1: mgmt_dat_o <= 1'b1;
                    3'd2, 3'd4, 3'd6: mgmt_clk_o <= 1'b1;
                    3'd3, 3'd5: mgmt_clk_o <= 1'b0;
                    default: begin mgmt_clk_oe <= 1'b0; mgmt_dat_oe <= 1'b0; end
                endcase
                ST_IDLE, ST_FIN: ;
            endcase
        end
    end

    // R1
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mgmt_clk_oe && !mgmt_dat_oe));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> busy);

    // R6
    retry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= RMAX);

    // R3
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && $past(st) == ST_SEND && mgmt_clk_o && $past(mgmt_clk_o))
            |-> $stable(mgmt_dat_o));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgmt_clk_oe) |-> ($past(st) == ST_STOP));

endmodule

// File: rtl/sermgmt_master.sv
module sermgmt_master #(
    parameter int DELAY_W     = 8,
    parameter int ACK_RETRIES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic               req_read,
    input  logic               req_noack,
    input  logic [15:0]        req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [7:0]         cfg_rd_cmd,
    input  logic [7:0]         cfg_wr_cmd,
    input  logic [DELAY_W-1:0] cfg_delay,
    output logic               busy,
    output logic               done,
    output logic [15:0]        rsp_rdata,
    output logic               rsp_err,
    output logic               mgmt_clk_o,
    output logic               mgmt_clk_oe,
    output logic               mgmt_dat_o,
    output logic               mgmt_dat_oe,
    input  logic               mgmt_dat_i
);
    logic go;
    logic run;

    sermgmt_pacer #(.DELAY_W(DELAY_W)) pacer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .dly   (cfg_delay),
        .go    (go)
    );

    sermgmt_seq #(.ACK_RETRIES(ACK_RETRIES)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .run         (run),
        .req_start   (req_start),
        .req_read    (req_read),
        .req_noack   (req_noack),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .cfg_rd_cmd  (cfg_rd_cmd),
        .cfg_wr_cmd  (cfg_wr_cmd),
        .busy        (busy),
        .done        (done),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .mgmt_clk_o  (mgmt_clk_o),
        .mgmt_clk_oe (mgmt_clk_oe),
        .mgmt_dat_o  (mgmt_dat_o),
        .mgmt_dat_oe (mgmt_dat_oe),
        .mgmt_dat_i  (mgmt_dat_i)
    );

endmodule

// File: tb/sermgmt_master_tb.sv
`timescale 1ns/1ps
module sermgmt_master_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_start = 1'b0, req_read = 1'b0, req_noack = 1'b0;
    logic [15:0] req_addr = 16'h0, req_wdata = 16'h0;
    logic [7:0]  rd_cmd = 8'hA9, wr_cmd = 8'hA8;
    logic [7:0]  dly = 8'd1;
    logic        busy, done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        mclk, mclk_oe, mdat, mdat_oe, mdat_i;

    logic [63:0] resp = 64'h0;
    int          rcnt = 0;
    assign mdat_i = mdat_oe ? mdat : resp[rcnt[5:0]];

    sermgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
        .req_noack(req_noack), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_rd_cmd(rd_cmd), .cfg_wr_cmd(wr_cmd), .cfg_delay(dly),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mgmt_clk_o(mclk), .mgmt_clk_oe(mclk_oe), .mgmt_dat_o(mdat),
        .mgmt_dat_oe(mdat_oe), .mgmt_dat_i(mdat_i)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor, sampled at falling system clock
    logic mon_clr = 1'b0;
    logic p_clk = 1'b0, p_coe = 1'b0, p_dat = 1'b1, p_doe = 1'b0;
    logic [63:0] wlog = 64'h0;
    int wcnt = 0, falls_hi = 0, rises_hi = 0, gap = 1000, min_gap = 1000, dones = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            wlog = 64'h0; wcnt = 0; rcnt = 0; falls_hi = 0; rises_hi = 0;
            gap = 1000; min_gap = 1000; dones = 0;
        end else begin
            if (mclk_oe && mdat_oe && !p_clk && mclk) begin
                wlog = {wlog[62:0], mdat}; wcnt++;
            end
            if (p_clk && !mclk && !p_doe && !mdat_oe) rcnt++;
            if (p_clk && mclk && p_doe && mdat_oe && p_dat && !mdat) falls_hi++;
            if (p_clk && mclk && p_doe && mdat_oe && !p_dat && mdat) rises_hi++;
            if ({mclk, mclk_oe, mdat, mdat_oe} != {p_clk, p_coe, p_dat, p_doe}) begin
                if (gap < min_gap) min_gap = gap;
                gap = 1;
            end else if (gap < 100000) gap++;
            if (done) dones++;
        end
        p_clk = mclk; p_coe = mclk_oe; p_dat = mdat; p_doe = mdat_oe;
    end

    // rd, noack, fail position (7 = none), fail count, delay, address, data
    localparam logic [47:0] VECS [0:7] = '{
        {1'b1, 1'b0, 3'd7, 3'd0, 8'd1, 16'h1234, 16'hA55A},
        {1'b0, 1'b0, 3'd7, 3'd0, 8'd2, 16'h8001, 16'h00FF},
        {1'b1, 1'b0, 3'd0, 3'd2, 8'd3, 16'hFFFF, 16'h0001},
        {1'b0, 1'b0, 3'd4, 3'd5, 8'd1, 16'h0000, 16'hC3E7},
        {1'b0, 1'b0, 3'd1, 3'd6, 8'd1, 16'h2468, 16'h1357},
        {1'b1, 1'b1, 3'd7, 3'd0, 8'd0, 16'h00A0, 16'h8000},
        {1'b0, 1'b1, 3'd7, 3'd0, 8'd1, 16'h0F0F, 16'hBEEF},
        {1'b1, 1'b0, 3'd2, 3'd6, 8'd1, 16'h5A5A, 16'h7E81}
    };

    function automatic logic [7:0] exp_byte(input int i, input logic rd,
                                            input logic [15:0] a, input logic [15:0] d);
        case (i)
            0: return rd ? rd_cmd : wr_cmd;
            1: return a[7:0];
            2: return a[15:8];
            3: return d[7:0];
            default: return d[15:8];
        endcase
    endfunction

    task automatic run_vec(input logic [47:0] v, input bit poke);
        logic rd = v[47], na = v[46];
        int fpos = int'(v[45:43]), nfail = int'(v[42:40]);
        logic [15:0] a = v[31:16], d = v[15:0];
        int nacks = rd ? 3 : (na ? 4 : 5);
        logic eerr = (nfail > 5) && (fpos < nacks);
        int nb = eerr ? fpos + 1 : (rd ? 3 : 5);
        int eff = (v[39:32] == 8'd0) ? 1 : int'(v[39:32]);
        logic [63:0] r = 64'h0, wexp = 64'h0;
        int pos = 0, nw = 0, guard = 0;
        logic got_err;
        logic [15:0] got_rd;

        for (int i = 0; i < nacks; i++) begin
            if (i == fpos) begin
                for (int k = 0; k < ((nfail > 6) ? 6 : nfail); k++) begin
                    r[pos] = 1'b1; pos++;
                end
                if (nfail > 5) break;
            end
            r[pos] = 1'b0; pos++;
        end
        if (rd && !eerr) begin
            for (int k = 7; k >= 0; k--) begin r[pos] = d[k]; pos++; end
            for (int k = 15; k >= 8; k--) begin r[pos] = d[k]; pos++; end
        end
        wexp = {wexp[61:0], 2'b11}; nw += 2;
        for (int b = 0; b < nb; b++) begin
            wexp = {wexp[55:0], exp_byte(b, rd, a, d)}; nw += 8;
        end
        if (rd && !eerr) begin wexp = {wexp[61:0], 2'b01}; nw += 2; end
        wexp = {wexp[60:0], 3'b011}; nw += 3;

        @(negedge clk); #1 mon_clr = 1'b1; resp = r; dly = v[39:32];
        @(negedge clk); #1 mon_clr = 1'b0;
        @(negedge clk);
        req_read = rd; req_noack = na; req_addr = a; req_wdata = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk("R11 busy after start", busy, 1'b1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req_read = ~rd; req_addr = 16'hDEAD; req_wdata = 16'h0BAD; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        got_err = rsp_err; got_rd = rsp_rdata;
        chk("R7 error flag", got_err, eerr);
        if (rd && !eerr) chk("R4 read data", got_rd, d);
        chk(rd ? "R4 written bit stream" : "R5 written bit stream", wlog, wexp);
        chk("R3 written bit count", wcnt, nw);
        chk(eerr ? "R7 released bits clocked" : (na ? "R8 released bits clocked"
                                                     : "R6 released bits clocked"), rcnt, pos);
        chk("R2 data fall with clock high", falls_hi, 1);
        chk("R9 data rise with clock high", rises_hi, 1);
        chk("R10 minimum pin change spacing", min_gap, eff);
        @(negedge clk);
        @(negedge clk);
        chk("R11 single done", dones, 1);
        chk("R1 idle after exchange", {busy, done, mclk_oe, mdat_oe}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {busy, done, mclk_oe, mdat_oe}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset release", {busy, done, mclk_oe, mdat_oe}, 4'b0000);

        for (int i = 0; i < 8; i++) run_vec(VECS[i], 1'b0);

        // R11: second start during a write is ignored
        run_vec({1'b0, 1'b0, 3'd7, 3'd0, 8'd1, 16'h4321, 16'h9876}, 1'b1);
        // R4: command codes come from configuration
        rd_cmd = 8'h3C; wr_cmd = 8'hC3;
        run_vec({1'b1, 1'b0, 3'd7, 3'd0, 8'd2, 16'h0102, 16'hFEDC}, 1'b0);
        run_vec({1'b0, 1'b0, 3'd3, 3'd1, 8'd1, 16'h0304, 16'h0506}, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule